// File: doc/BRIEF.md
# I2C Passive Bus Protocol Monitor

This block watches the two wires of an I2C bus without driving them. It brings SCL and SDA into the system clock domain and detects their edges there. It then rebuilds the framing of each transaction and hands debug logic one event per protocol occurrence: start conditions, stop conditions, address bytes, data bytes and the acknowledge level that closes each byte. Events leave on a valid/ready stream with a kind code, a byte value and a NACK bit.

Alongside the stream the monitor raises four fault indications. The first is a bus that stays non-idle outside a transaction for too long. The second is a clock low phase inside a transaction that outlasts a stretch limit. The third is a start or stop condition that cuts into the middle of a byte. The fourth is a register-read pattern that was split by a STOP where a repeated START belonged. It has no storage for captures and gives no meaning to register contents.

Top module: `i2c_bus_watch`

## Requirements
- R1: A falling SDA while SCL is high emits an event of kind 0 (START) when no transaction is open, and kind 1 (repeated START) when a start was seen with no stop since; the byte and NACK fields are 0.
- R2: A rising SDA while SCL is high emits kind 2 (STOP) with byte and NACK fields 0, and closes the transaction.
- R3: The first complete byte after any start emits kind 3 (address); the byte field holds the 7-bit address in bits 7:1 and the direction bit in bit 0 (0 write, 1 read), sampled MSB first on SCL rising edges.
- R4: Each later complete byte emits kind 4 (data) with the byte MSB first; for address and data events the NACK field equals the SDA level at the ninth SCL rising edge (0 ACK, 1 NACK).
- R5: SCL pulses while no transaction is open produce no events and no framing error.
- R6: Outside a transaction, when SCL or SDA stays low for STUCK_CYCLES clocks, `stuck_o` goes high; it stays low inside a transaction and drops soon after both lines are high again.
- R7: Inside a transaction, an SCL low phase of STRETCH_CYCLES clocks raises `stretch_o`, which drops soon after SCL goes high.
- R8: A start or stop condition that arrives after two or more bits of a byte were sampled pulses `frame_err_o` for one cycle; the condition's own event is still emitted.
- R9: When a STOP closes a segment made of a write address and exactly one complete data byte, and the next address byte is a read to the same 7-bit address, `no_rstart_o` pulses for one cycle; every address byte clears that pending pattern.
- R10: While `ev_valid_o` is high and `ev_ready_i` is low, the kind, byte and NACK outputs hold steady; an event decoded in that time is dropped.
- R11: After reset, `ev_valid_o` and all four fault outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Observed SCL level |
| sda_i | input | 1 | Observed SDA level |
| ev_valid_o | output | 1 | Event present on the stream |
| ev_ready_i | input | 1 | Consumer accepts the event |
| ev_kind_o | output | 3 | Event kind (0 start, 1 repeated start, 2 stop, 3 address, 4 data) |
| ev_data_o | output | 8 | Byte carried by address or data events |
| ev_nack_o | output | 1 | Acknowledge level of the byte, 1 for NACK |
| frame_err_o | output | 1 | One-cycle pulse on a condition that broke a byte |
| no_rstart_o | output | 1 | One-cycle pulse on a register read split by STOP |
| stuck_o | output | 1 | Idle bus held low past the threshold |
| stretch_o | output | 1 | Clock low phase past the stretch limit |

## Verification
The bench goes after the SCL rise that precedes every stop and repeated start. A decoder that counted it as a data bit would raise a framing error on every transaction or shift the bytes by one. Split register reads to the same address, to a different address and with a proper repeated start tell a missing-repeated-START detector that ignores the address or the segment shape apart from a correct one. Stretch and stuck thresholds are probed just below and just above their limits, and inside and outside a transaction, which exposes a wrong threshold or a timer keyed to the wrong bus state. A stalled consumer shows whether a held event changes under it.

// File: rtl/i2cw_pkg.sv
// Package: shared event kind encoding for the I2C bus monitor.
// Assumes: consumers decode the 3-bit kind field with these values.
package i2cw_pkg;
    typedef enum logic [2:0] {
        EV_START  = 3'd0,
        EV_RSTART = 3'd1,
        EV_STOP   = 3'd2,
        EV_ADDR   = 3'd3,
        EV_DATA   = 3'd4
    } i2cw_ev_e;
endpackage

// File: rtl/i2cw_sync.sv
// Module: i2cw_sync
// Brings one asynchronous bus line into the clock domain through a
// flop chain and keeps the previous synchronized level for edge detection.
// Assumes: the line idles high, so every stage resets to 1.
module i2cw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o,
    output logic prev_o
);
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    // Shift the raw level through the chain and remember the last output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '1;
            prev_q <= 1'b1;
        end else begin
            if (STAGES > 1) begin
                pipe_q <= {pipe_q[STAGES-2:0], raw_i};
            end else begin
                pipe_q <= raw_i;
            end
            prev_q <= pipe_q[STAGES-1];
        end
    end

    assign level_o = pipe_q[STAGES-1];
    assign prev_o  = prev_q;
endmodule

// File: rtl/i2cw_limit_counter.sv
// Module: i2cw_limit_counter
// Counts consecutive enabled cycles and saturates at LIMIT; hit_o is high
// while the count sits at the limit. Dropping the enable clears the count.
// Assumes: LIMIT >= 1.
module i2cw_limit_counter #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Advance while enabled, hold at the limit, restart when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit_o = (cnt_q == LIM);

    // R6 and R7: releasing the condition clears the flag on the next cycle.
    assert_clear_on_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !hit_o)
        else $error("limit flag stayed up after release");

    // R6 and R7: the flag can only rise after the condition held a cycle.
    assert_rise_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_o) |-> $past(en_i))
        else $error("limit flag rose without its condition");
endmodule

// File: rtl/i2cw_decoder.sv
// Module: i2cw_decoder
// Rebuilds I2C framing from synchronized SCL/SDA levels and their previous
// values. Emits one registered event pulse per start, stop and byte, a
// framing error pulse and a split-register-read pulse.
// Assumes: SCL and SDA do not change in the same synchronized cycle; the
// SCL rise just before a stop or repeated start is a legal first bit slot.
module i2cw_decoder
    import i2cw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     scl_prev_i,
    input  logic     sda_i,
    input  logic     sda_prev_i,
    output logic     ev_stb_o,
    output i2cw_ev_e ev_kind_o,
    output logic [7:0] ev_data_o,
    output logic     ev_nack_o,
    output logic     frame_err_o,
    output logic     no_rstart_o,
    output logic     in_frame_o
);
    logic       start_c, stop_c, scl_rise_c;
    logic       in_frame_q, first_q;
    logic [3:0] bit_cnt_q;
    logic [7:0] shreg_q;
    logic       hdr_write_q;
    logic [6:0] hdr_addr_q;
    logic [1:0] data_n_q;
    logic       cand_q;
    logic [6:0] cand_addr_q;
    logic       ev_stb_q, ferr_q, miss_q, ev_nack_q;
    i2cw_ev_e   ev_kind_q;
    logic [7:0] ev_data_q;
    logic       broken_c;

    // Classify the current cycle: start, stop or clock rising edge.
    always_comb begin
        start_c    = scl_i && scl_prev_i && sda_prev_i && !sda_i;
        stop_c     = scl_i && scl_prev_i && !sda_prev_i && sda_i;
        scl_rise_c = scl_i && !scl_prev_i;
        broken_c   = in_frame_q && (bit_cnt_q > 4'd1);
    end

    // Framing state machine, event generation and split-read tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q  <= 1'b0;
            first_q     <= 1'b0;
            bit_cnt_q   <= '0;
            shreg_q     <= '0;
            hdr_write_q <= 1'b0;
            hdr_addr_q  <= '0;
            data_n_q    <= '0;
            cand_q      <= 1'b0;
            cand_addr_q <= '0;
            ev_stb_q    <= 1'b0;
            ev_kind_q   <= EV_START;
            ev_data_q   <= '0;
            ev_nack_q   <= 1'b0;
            ferr_q      <= 1'b0;
            miss_q      <= 1'b0;
        end else begin
            ev_stb_q <= 1'b0;
            ferr_q   <= 1'b0;
            miss_q   <= 1'b0;
            if (start_c) begin
                ev_stb_q    <= 1'b1;
                ev_kind_q   <= in_frame_q ? EV_RSTART : EV_START;
                ev_data_q   <= '0;
                ev_nack_q   <= 1'b0;
                ferr_q      <= broken_c;
                in_frame_q  <= 1'b1;
                first_q     <= 1'b1;
                bit_cnt_q   <= '0;
                hdr_write_q <= 1'b0;
                data_n_q    <= '0;
            end else if (stop_c) begin
                ev_stb_q    <= 1'b1;
                ev_kind_q   <= EV_STOP;
                ev_data_q   <= '0;
                ev_nack_q   <= 1'b0;
                ferr_q      <= broken_c;
                cand_q      <= in_frame_q && hdr_write_q && !first_q
                               && (data_n_q == 2'd1) && !broken_c;
                cand_addr_q <= hdr_addr_q;
                in_frame_q  <= 1'b0;
                bit_cnt_q   <= '0;
            end else if (scl_rise_c && in_frame_q) begin
                if (bit_cnt_q != 4'd8) begin
                    shreg_q   <= {shreg_q[6:0], sda_i};
                    bit_cnt_q <= bit_cnt_q + 4'd1;
                end else begin
                    ev_stb_q  <= 1'b1;
                    ev_kind_q <= first_q ? EV_ADDR : EV_DATA;
                    ev_data_q <= shreg_q;
                    ev_nack_q <= sda_i;
                    bit_cnt_q <= '0;
                    first_q   <= 1'b0;
                    if (first_q) begin
                        hdr_write_q <= !shreg_q[0];
                        hdr_addr_q  <= shreg_q[7:1];
                        data_n_q    <= '0;
                        miss_q      <= cand_q && shreg_q[0] && (shreg_q[7:1] == cand_addr_q);
                        cand_q      <= 1'b0;
                    end else if (data_n_q != 2'd2) begin
                        data_n_q <= data_n_q + 2'd1;
                    end
                end
            end
        end
    end

    assign ev_stb_o    = ev_stb_q;
    assign ev_kind_o   = ev_kind_q;
    assign ev_data_o   = ev_data_q;
    assign ev_nack_o   = ev_nack_q;
    assign frame_err_o = ferr_q;
    assign no_rstart_o = miss_q;
    assign in_frame_o  = in_frame_q;

    // R1: a repeated start is only reported inside an open transaction.
    assert_rstart_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stb_q && ev_kind_q == EV_RSTART) |-> $past(in_frame_q))
        else $error("repeated start outside a transaction");

    // R2: after a stop event the transaction is closed.
    assert_stop_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stb_q && ev_kind_q == EV_STOP) |-> !in_frame_q)
        else $error("transaction still open after stop");

    // R8: a framing error accompanies a start or stop event.
    assert_ferr_with_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_q |-> (ev_stb_q && (ev_kind_q == EV_START || ev_kind_q == EV_RSTART
                                 || ev_kind_q == EV_STOP)))
        else $error("framing error without a bus condition");

    // R9: the split-read pulse comes with a read-direction address event.
    assert_miss_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q |-> (ev_stb_q && ev_kind_q == EV_ADDR && ev_data_q[0]))
        else $error("split-read warning without a read address");
endmodule

// File: rtl/i2c_bus_watch.sv
// Module: i2c_bus_watch (top)
// Passive I2C observer: synchronizes both lines, decodes framing into an
// event stream, and raises stuck-bus, stretch, framing and split-read
// indications.
// Assumes: one system clock much faster than SCL; the consumer may stall,
// in which case events decoded meanwhile are dropped.
module i2c_bus_watch #(
    parameter int STUCK_CYCLES   = 200,
    parameter int STRETCH_CYCLES = 100,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       ev_valid_o,
    input  logic       ev_ready_i,
    output logic [2:0] ev_kind_o,
    output logic [7:0] ev_data_o,
    output logic       ev_nack_o,
    output logic       frame_err_o,
    output logic       no_rstart_o,
    output logic       stuck_o,
    output logic       stretch_o
);
    import i2cw_pkg::*;

    localparam int LINES = 2;

    logic [LINES-1:0] raw_lines, lvl_lines, prv_lines;
    logic             dec_stb, dec_nack, in_frame;
    i2cw_ev_e         dec_kind;
    logic [7:0]       dec_data;
    logic             vld_q, nack_q;
    logic [2:0]       kind_q;
    logic [7:0]       data_q;
    logic             stuck_en, stretch_en;

    assign raw_lines = {sda_i, scl_i};

    // One synchronizer per bus line: index 0 is SCL, index 1 is SDA.
    for (genvar gi = 0; gi < LINES; gi++) begin : g_line
        i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_lines[gi]),
            .level_o (lvl_lines[gi]),
            .prev_o  (prv_lines[gi])
        );
    end

    i2cw_decoder u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (lvl_lines[0]),
        .scl_prev_i  (prv_lines[0]),
        .sda_i       (lvl_lines[1]),
        .sda_prev_i  (prv_lines[1]),
        .ev_stb_o    (dec_stb),
        .ev_kind_o   (dec_kind),
        .ev_data_o   (dec_data),
        .ev_nack_o   (dec_nack),
        .frame_err_o (frame_err_o),
        .no_rstart_o (no_rstart_o),
        .in_frame_o  (in_frame)
    );

    // Timer enables: idle bus not fully high, or clock low inside a transfer.
    always_comb begin
        stuck_en   = !in_frame && !(lvl_lines[0] && lvl_lines[1]);
        stretch_en = in_frame && !lvl_lines[0];
    end

    i2cw_limit_counter #(.LIMIT(STUCK_CYCLES)) u_stuck (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (stuck_en),
        .hit_o (stuck_o)
    );

    i2cw_limit_counter #(.LIMIT(STRETCH_CYCLES)) u_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (stretch_en),
        .hit_o (stretch_o)
    );

    // Single-entry output stage: load when empty or draining, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            kind_q <= '0;
            data_q <= '0;
            nack_q <= 1'b0;
        end else if (dec_stb && (!vld_q || ev_ready_i)) begin
            vld_q  <= 1'b1;
            kind_q <= dec_kind;
            data_q <= dec_data;
            nack_q <= dec_nack;
        end else if (ev_ready_i) begin
            vld_q <= 1'b0;
        end
    end

    assign ev_valid_o = vld_q;
    assign ev_kind_o  = kind_q;
    assign ev_data_o  = data_q;
    assign ev_nack_o  = nack_q;

    // R10: a stalled event keeps its contents until accepted.
    assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !ev_ready_i) |=> (vld_q && $stable(kind_q) && $stable(data_q)
                                    && $stable(nack_q)))
        else $error("stalled event changed");

    // R6: the idle-bus flag never rises while a transaction is open.
    assert_stuck_idle_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame |=> !stuck_o)
        else $error("stuck flag inside a transaction");
endmodule

// File: tb/i2c_bus_watch_tb.sv
module i2c_bus_watch_tb;
    localparam int Q       = 6;
    localparam int STUCK   = 200;
    localparam int STRETCH = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_b = 1'b1, sda_b = 1'b1;
    logic ev_ready_i = 1'b1;
    logic ev_valid_o, ev_nack_o, frame_err_o, no_rstart_o, stuck_o, stretch_o;
    logic [2:0] ev_kind_o;
    logic [7:0] ev_data_o;

    int total = 0, bad = 0;
    int ferr_cnt = 0, miss_cnt = 0, exp_ferr = 0, exp_miss = 0;
    int ready_mode = 2;  // 0 stall, 1 random, 2 always ready
    logic [11:0] expq[$];
    logic [11:0] gotq[$];

    // Bench reference model state for split register reads (R9).
    bit       in_frame_b = 0, cand_b = 0, seg_write = 0, seg_partial = 0;
    bit [6:0] cand_addr_b = 0, seg_addr = 0;
    int       seg_data_n = 0;

    always #5 clk = ~clk;

    i2c_bus_watch #(.STUCK_CYCLES(STUCK), .STRETCH_CYCLES(STRETCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_b), .sda_i(sda_b),
        .ev_valid_o(ev_valid_o), .ev_ready_i(ev_ready_i), .ev_kind_o(ev_kind_o),
        .ev_data_o(ev_data_o), .ev_nack_o(ev_nack_o), .frame_err_o(frame_err_o),
        .no_rstart_o(no_rstart_o), .stuck_o(stuck_o), .stretch_o(stretch_o)
    );

    // Ready driver, updated just after each rising edge.
    always @(posedge clk) begin
        #2;
        case (ready_mode)
            0: ev_ready_i = 1'b0;
            1: ev_ready_i = ($urandom % 4) != 0;
            default: ev_ready_i = 1'b1;
        endcase
    end

    // Output monitor at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (ev_valid_o && ev_ready_i) gotq.push_back({ev_kind_o, ev_data_o, ev_nack_o});
            if (frame_err_o) ferr_cnt++;
            if (no_rstart_o) miss_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Model hooks: push the expected event and update the split-read model.
    task automatic m_start(input bit rep);
        expq.push_back({rep ? 3'd1 : 3'd0, 8'h00, 1'b0});
        in_frame_b = 1; seg_write = 0; seg_data_n = 0; seg_partial = 0;
    endtask

    task automatic m_byte(input logic [7:0] b, input bit n, input bit first);
        expq.push_back({first ? 3'd3 : 3'd4, b, n});
        if (first) begin
            if (cand_b && b[0] && b[7:1] == cand_addr_b) exp_miss++;
            cand_b = 0; seg_write = !b[0]; seg_addr = b[7:1]; seg_data_n = 0;
        end else begin
            seg_data_n++;
        end
    endtask

    task automatic m_stop();
        expq.push_back({3'd2, 8'h00, 1'b0});
        cand_b = in_frame_b && seg_write && seg_data_n == 1 && !seg_partial;
        cand_addr_b = seg_addr;
        in_frame_b = 0;
    endtask

    // Bus drivers; all leave SCL low except the stop.
    task automatic do_start(input bit rep);
        if (rep) begin sda_b = 1; wq(Q); scl_b = 1; wq(Q); end
        sda_b = 0; wq(Q); scl_b = 0; wq(Q);
        m_start(rep);
    endtask

    task automatic do_stop();
        sda_b = 0; wq(Q); scl_b = 1; wq(Q); sda_b = 1; wq(Q);
        m_stop();
    endtask

    task automatic send_bit(input bit b);
        sda_b = b; wq(Q); scl_b = 1; wq(2 * Q); scl_b = 0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit n, input bit first);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        send_bit(n);
        m_byte(b, n, first);
    endtask

    // Compare delivered events against the expected list.
    task automatic drain();
        string rq;
        wq(40);
        chk(gotq.size() == expq.size(), "R1", "event count", gotq.size(), expq.size());
        if (gotq.size() == expq.size()) begin
            for (int i = 0; i < expq.size(); i++) begin
                case (expq[i][11:9])
                    3'd0, 3'd1: rq = "R1";
                    3'd2:       rq = "R2";
                    3'd3:       rq = "R3";
                    default:    rq = "R4";
                endcase
                chk(gotq[i] == expq[i], rq, "event {kind,byte,nack}", gotq[i], expq[i]);
            end
        end
        gotq.delete(); expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [11:0] held;
        void'($urandom(32'h1A2B3C));
        wq(5); rst_n = 1; wq(5);
        // R11: reset state.
        chk(!ev_valid_o && !frame_err_o && !no_rstart_o && !stuck_o && !stretch_o,
            "R11", "outputs after reset", {ev_valid_o, stuck_o, stretch_o}, 0);

        // R5: clock pulses on an idle bus are ignored.
        for (int i = 0; i < 12; i++) begin scl_b = 0; wq(Q); scl_b = 1; wq(Q); end
        wq(20);
        chk(gotq.size() == 0, "R5", "events from idle clocking", gotq.size(), 0);
        chk(ferr_cnt == 0, "R5", "framing errors from idle clocking", ferr_cnt, 0);

        // R1 R3 R4 R2: directed write with ACK then NACK, repeated start read.
        do_start(0); send_byte(8'hA4, 0, 1); send_byte(8'h3C, 0, 0);
        do_start(1); send_byte(8'hA5, 0, 1); send_byte(8'hFF, 1, 0); do_stop();
        wq(4 * Q); drain();
        chk(ferr_cnt == 0, "R8", "no framing error on clean traffic", ferr_cnt, 0);

        // R10: stalled consumer holds the event.
        ready_mode = 0; wq(3);
        do_start(0); wq(30);
        chk(ev_valid_o && ev_kind_o == 3'd0, "R10", "stalled start visible",
            {ev_valid_o, ev_kind_o}, 4'b1000);
        held = {ev_kind_o, ev_data_o, ev_nack_o};
        send_byte(8'h12, 1, 1);
        chk({ev_kind_o, ev_data_o, ev_nack_o} == held && ev_valid_o, "R10",
            "held event unchanged", {ev_kind_o, ev_data_o, ev_nack_o}, held);
        void'(expq.pop_back());  // the address decoded during the stall is dropped
        ready_mode = 2; wq(5);
        do_stop(); wq(4 * Q); drain();

        // R9: split register read to the same address warns.
        do_start(0); send_byte(8'hA0, 0, 1); send_byte(8'h10, 0, 0); do_stop(); wq(4 * Q);
        do_start(0); send_byte(8'hA1, 0, 1); send_byte(8'h55, 1, 0); do_stop(); wq(4 * Q);
        drain();
        chk(miss_cnt == 1 && exp_miss == 1, "R9", "split read same address", miss_cnt, 1);
        // R9: different address, and a proper repeated start, do not warn.
        do_start(0); send_byte(8'hA0, 0, 1); send_byte(8'h10, 0, 0); do_stop(); wq(4 * Q);
        do_start(0); send_byte(8'hB1, 0, 1); send_byte(8'h55, 1, 0); do_stop(); wq(4 * Q);
        do_start(0); send_byte(8'hA0, 0, 1); send_byte(8'h10, 0, 0);
        do_start(1); send_byte(8'hA1, 0, 1); send_byte(8'h66, 1, 0); do_stop(); wq(4 * Q);
        drain();
        chk(miss_cnt == 1, "R9", "no warning for other address or repeated start", miss_cnt, 1);

        // R8: stop in the middle of a byte.
        do_start(0); send_byte(8'hC2, 0, 1);
        send_bit(1); send_bit(0); send_bit(1);
        seg_partial = 1; do_stop(); wq(4 * Q);
        exp_ferr++;
        drain();
        chk(ferr_cnt == exp_ferr, "R8", "framing error on broken byte", ferr_cnt, exp_ferr);

        // R7: stretch below and above the limit, inside a transaction.
        do_start(0); send_byte(8'h44, 0, 1);
        wq(STRETCH - 30);
        chk(!stretch_o, "R7", "stretch flag below limit", stretch_o, 0);
        wq(60);
        chk(stretch_o, "R7", "stretch flag above limit", stretch_o, 1);
        chk(!stuck_o, "R6", "stuck flag low inside transaction", stuck_o, 0);
        send_byte(8'h99, 0, 0);
        chk(!stretch_o, "R7", "stretch flag cleared by clock", stretch_o, 0);
        do_stop(); wq(4 * Q); drain();

        // R6: idle bus with SCL held low.
        scl_b = 0; wq(STUCK - 30);
        chk(!stuck_o, "R6", "stuck flag below threshold", stuck_o, 0);
        wq(60);
        chk(stuck_o, "R6", "stuck flag above threshold", stuck_o, 1);
        scl_b = 1; wq(10);
        chk(!stuck_o, "R6", "stuck flag cleared when idle", stuck_o, 0);
        chk(gotq.size() == 0, "R5", "no events from idle stuck clock", gotq.size(), 0);

        // Random traffic with random back-pressure.
        ready_mode = 1;
        for (int t = 0; t < 40; t++) begin
            int segs = 1 + ($urandom % 2);
            do_start(0);
            for (int s = 0; s < segs; s++) begin
                int nb = 1 + ($urandom % 2);
                logic [7:0] ab = {(($urandom % 2) ? 7'h50 : 7'h51), 1'(($urandom % 2))};
                if (s > 0) do_start(1);
                send_byte(ab, 1'($urandom % 2), 1);
                for (int k = 0; k < nb; k++) send_byte(8'($urandom), 1'($urandom % 2), 0);
            end
            do_stop(); wq(4 * Q);
            chk(!stuck_o && !stretch_o, "R6", "no timer flags on normal traffic",
                {stuck_o, stretch_o}, 0);
        end
        ready_mode = 2;
        drain();
        chk(miss_cnt == exp_miss, "R9", "split-read count on random traffic", miss_cnt, exp_miss);
        chk(ferr_cnt == exp_ferr, "R8", "framing errors on random traffic", ferr_cnt, exp_ferr);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule